// File: doc/BRIEF.md
# Machine Check Bank Logger

This block keeps a set of error-reporting banks for a processor core, together with three global registers: a capability word, a global status word and a global control word. Each bank holds four 64-bit registers: a control mask, a status word, an error address and an auxiliary word. An injection port delivers one error at a time. The error carries a bank index, a status word, an address, an auxiliary word, a replacement global status and an unconditional flag.

In the clock that accepts an injection, the block applies one of five outcomes. It can reject or ignore the error. It can record an uncorrected error and raise a machine-check interrupt. It can request a reset. It can record a corrected error. It can mark an existing uncorrected entry as overflowed. Which outcome applies depends on the incoming status, the state already held in the bank, the global in-progress bit and a core-side machine-check enable input.

Software reads and writes every register through a simple register port. A write on that port wins over an injection presented in the same clock.

Top module: `mcb_logger`

## Requirements
- R1: After reset, every bank register, the global status and the global control read as zero, the capability reads CAP_INIT (0x104 by default: 4 banks, control-present bit set), and both pulse outputs are low.
- R2: Register map by word address: 0 is capability, 1 is global status, 2 is global control, and 3 reads zero. Bank b, field f sits at 4+4*b+f, with f = 0 for control, 1 for status, 2 for address and 3 for auxiliary. A read returns the value one clock after the address is presented.
- R3: An injection changes nothing and raises no pulse when any of these holds: the capability is zero, the bank index is not below capability bits [7:0], or status bit 63 (valid) is clear.
- R4: When global status bit 2 (in progress) is set, an error with status bit 55 (action required) clear and the unconditional flag low is ignored.
- R5: An uncorrected error (status bit 61 set) is dropped when capability bit 8 (control present) is set and the global control is not all ones, or when the bank's control register is not all ones.
- R6: An uncorrected error that is not dropped raises a one-cycle reset request, and leaves the banks and the global status untouched, when the core enable input is low or the in-progress bit is set.
- R7: Otherwise an uncorrected error is logged. The status gets bit 62 (overflow) set if the bank's old status was valid. Address, auxiliary, status and global status are written, and a one-cycle interrupt pulse follows the accepting edge.
- R8: A corrected error replaces the bank's status, address and auxiliary when the bank is empty or holds a corrected entry. It sets the overflow bit if the old entry was valid, raises no pulse, and leaves the global status alone.
- R9: A corrected error arriving on a bank with a valid uncorrected entry only sets that entry's overflow bit. Its address and auxiliary stay as they were.
- R10: When a register-port write and an injection share a clock, the write takes effect and the injection is discarded.
- R11: The interrupt and the reset request are each high for exactly one clock per injection, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mce_en | input | 1 | Core-side machine-check enable |
| inj_valid | input | 1 | Injection request for this clock |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | 64 | Error status word |
| inj_addr | input | 64 | Error address |
| inj_misc | input | 64 | Auxiliary error word |
| inj_gstat | input | 64 | Global status to load on an uncorrected log |
| inj_uncond | input | 1 | Bypass the in-progress ignore rule |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Reset request pulse |

## Verification
An injection is decided and applied on the clock edge that samples it. The interrupt or reset pulse is therefore high in the cycle right after that edge and low one edge later. Register contents show up on the read port one edge after the address is applied. The bench drives inputs on the falling edge and samples each pulse one time unit after the accepting rising edge. It confirms the pulse has cleared after the following edge, and it reads back every affected register only once the injection has been released. This way each check lands in the cycle its result is due.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int MC_W = 64;

  localparam int ST_VALID = 63;
  localparam int ST_OVER  = 62;
  localparam int ST_UNCOR = 61;
  localparam int ST_ACTRQ = 55;

  localparam int GS_INPROG = 2;
  localparam int CAP_CTLP  = 8;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_LOG_UC,
    ACT_RESET,
    ACT_LOG_CE,
    ACT_OVER_ONLY
  } mc_act_e;
endpackage

// File: rtl/mcb_decide.sv
module mcb_decide
  import mcb_pkg::*;
#(
  parameter int NB   = 4,
  parameter int IW   = 8
) (
  input  logic            go,
  input  logic            mce_en,
  input  logic [MC_W-1:0] cap,
  input  logic [MC_W-1:0] gstat,
  input  logic [MC_W-1:0] gctl,
  input  logic [IW-1:0]   inj_bank,
  input  logic [MC_W-1:0] inj_status,
  input  logic            inj_uncond,
  input  logic [MC_W-1:0] bank_ctl,
  input  logic [MC_W-1:0] bank_stat,
  output mc_act_e         act,
  output logic [MC_W-1:0] new_stat
);
  logic accept, busy;

  assign busy   = gstat[GS_INPROG];
  assign accept = go && (cap != '0) && (inj_bank < cap[7:0]) &&
                  (32'(inj_bank) < NB) && inj_status[ST_VALID];

  always_comb begin
    act      = ACT_NONE;
    new_stat = inj_status;
    if (accept) begin
      if (busy && !inj_status[ST_ACTRQ] && !inj_uncond) begin
        act = ACT_NONE;
      end else if (inj_status[ST_UNCOR]) begin
        if ((cap[CAP_CTLP] && gctl != '1) || bank_ctl != '1) begin
          act = ACT_NONE;
        end else if (!mce_en || busy) begin
          act = ACT_RESET;
        end else begin
          act = ACT_LOG_UC;
          if (bank_stat[ST_VALID]) new_stat[ST_OVER] = 1'b1;
        end
      end else if (!bank_stat[ST_VALID] || !bank_stat[ST_UNCOR]) begin
        act = ACT_LOG_CE;
        if (bank_stat[ST_VALID]) new_stat[ST_OVER] = 1'b1;
      end else begin
        act      = ACT_OVER_ONLY;
        new_stat = bank_stat;
        new_stat[ST_OVER] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcb_bank_file.sv
module mcb_bank_file
  import mcb_pkg::*;
#(
  parameter int NB = 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [BW-1:0]   wr_bank,
  input  logic [1:0]      wr_field,
  input  logic [MC_W-1:0] wr_data,
  input  logic            hw_en,
  input  logic            hw_am_we,
  input  logic [BW-1:0]   hw_bank,
  input  logic [MC_W-1:0] hw_stat,
  input  logic [MC_W-1:0] hw_addr,
  input  logic [MC_W-1:0] hw_misc,
  output logic [MC_W-1:0] ctl_o  [NB],
  output logic [MC_W-1:0] stat_o [NB],
  output logic [MC_W-1:0] addr_o [NB],
  output logic [MC_W-1:0] misc_o [NB]
);
  for (genvar i = 0; i < NB; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_o[i]  <= '0;
        stat_o[i] <= '0;
        addr_o[i] <= '0;
        misc_o[i] <= '0;
      end else if (wr_en && wr_bank == BW'(i)) begin
        case (wr_field)
          2'd0:    ctl_o[i]  <= wr_data;
          2'd1:    stat_o[i] <= wr_data;
          2'd2:    addr_o[i] <= wr_data;
          default: misc_o[i] <= wr_data;
        endcase
      end else if (hw_en && hw_bank == BW'(i)) begin
        stat_o[i] <= hw_stat;
        if (hw_am_we) begin
          addr_o[i] <= hw_addr;
          misc_o[i] <= hw_misc;
        end
      end
    end
  end

  // R10
  no_collide_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hw_en));
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
  import mcb_pkg::*;
#(
  parameter int              NB       = 4,
  parameter int              IW       = 8,
  parameter logic [MC_W-1:0] CAP_INIT = 64'h104,
  localparam int AW = $clog2(4 * (NB + 1)),
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mce_en,
  input  logic            inj_valid,
  input  logic [IW-1:0]   inj_bank,
  input  logic [63:0]     inj_status,
  input  logic [63:0]     inj_addr,
  input  logic [63:0]     inj_misc,
  input  logic [63:0]     inj_gstat,
  input  logic            inj_uncond,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [63:0]     reg_wdata,
  output logic [63:0]     reg_rdata,
  output logic            mce_irq,
  output logic            reset_req
);
  logic [MC_W-1:0] cap_q, gstat_q, gctl_q;
  logic [MC_W-1:0] ctl_a [NB];
  logic [MC_W-1:0] stat_a [NB];
  logic [MC_W-1:0] addr_a [NB];
  logic [MC_W-1:0] misc_a [NB];

  // register-port decode
  logic [AW-1:0] rbank_w;
  logic          rbank_ok;
  logic [BW-1:0] rbank;
  logic [1:0]    rfield;
  assign rbank_w  = (reg_addr >> 2) - AW'(1);
  assign rbank_ok = (reg_addr >= AW'(4)) && (32'(rbank_w) < NB);
  assign rbank    = BW'(rbank_w);
  assign rfield   = reg_addr[1:0];

  // injection bank select
  logic [BW-1:0]   ibank;
  logic [MC_W-1:0] sel_ctl, sel_stat;
  assign ibank    = BW'(inj_bank);
  assign sel_ctl  = (32'(inj_bank) < NB) ? ctl_a[ibank]  : '0;
  assign sel_stat = (32'(inj_bank) < NB) ? stat_a[ibank] : '0;

  mc_act_e         act;
  logic [MC_W-1:0] new_stat;

  mcb_decide #(.NB(NB), .IW(IW)) u_dec (
    .go        (inj_valid && !reg_we),
    .mce_en    (mce_en),
    .cap       (cap_q),
    .gstat     (gstat_q),
    .gctl      (gctl_q),
    .inj_bank  (inj_bank),
    .inj_status(inj_status),
    .inj_uncond(inj_uncond),
    .bank_ctl  (sel_ctl),
    .bank_stat (sel_stat),
    .act       (act),
    .new_stat  (new_stat)
  );

  logic hw_en;
  assign hw_en = (act == ACT_LOG_UC) || (act == ACT_LOG_CE) || (act == ACT_OVER_ONLY);

  mcb_bank_file #(.NB(NB)) u_banks (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_we && rbank_ok),
    .wr_bank (rbank),
    .wr_field(rfield),
    .wr_data (reg_wdata),
    .hw_en   (hw_en),
    .hw_am_we(act != ACT_OVER_ONLY),
    .hw_bank (ibank),
    .hw_stat (new_stat),
    .hw_addr (inj_addr),
    .hw_misc (inj_misc),
    .ctl_o   (ctl_a),
    .stat_o  (stat_a),
    .addr_o  (addr_a),
    .misc_o  (misc_a)
  );

  logic [MC_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rbank_ok) begin
      case (rfield)
        2'd0:    rd_mux = ctl_a[rbank];
        2'd1:    rd_mux = stat_a[rbank];
        2'd2:    rd_mux = addr_a[rbank];
        default: rd_mux = misc_a[rbank];
      endcase
    end else begin
      case (reg_addr)
        AW'(0):  rd_mux = cap_q;
        AW'(1):  rd_mux = gstat_q;
        AW'(2):  rd_mux = gctl_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q     <= CAP_INIT;
      gstat_q   <= '0;
      gctl_q    <= '0;
      mce_irq   <= 1'b0;
      reset_req <= 1'b0;
      reg_rdata <= '0;
    end else begin
      mce_irq   <= (act == ACT_LOG_UC);
      reset_req <= (act == ACT_RESET);
      reg_rdata <= rd_mux;
      if (reg_we) begin
        case (reg_addr)
          AW'(0):  cap_q   <= reg_wdata;
          AW'(1):  gstat_q <= reg_wdata;
          AW'(2):  gctl_q  <= reg_wdata;
          default: ;
        endcase
      end else if (act == ACT_LOG_UC) begin
        gstat_q <= inj_gstat;
      end
    end
  end

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mce_irq && reset_req));
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    mce_irq |-> $past(inj_valid && !reg_we && inj_status[ST_UNCOR]));
  // R6
  rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(inj_valid && !reg_we && inj_status[ST_UNCOR]));
  // R7
  gstat_log_chk: assert property (@(posedge clk) disable iff (rst)
    mce_irq |-> gstat_q == $past(inj_gstat));
endmodule

// File: tb/sim_mcb_logger.sv
`timescale 1ns/1ps
module sim_mcb_logger;
  localparam logic [63:0] VAL  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] OVR  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] UC   = 64'h2000_0000_0000_0000;
  localparam logic [63:0] AR   = 64'h0080_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst = 1, mce_en = 1;
  logic inj_valid = 0, inj_uncond = 0;
  logic [7:0]  inj_bank = 0;
  logic [63:0] inj_status = 0, inj_addr = 0, inj_misc = 0, inj_gstat = 0;
  logic reg_we = 0;
  logic [4:0]  reg_addr = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic mce_irq, reset_req;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mcb_logger u0 (
    .clk(clk), .rst(rst), .mce_en(mce_en),
    .inj_valid(inj_valid), .inj_bank(inj_bank), .inj_status(inj_status),
    .inj_addr(inj_addr), .inj_misc(inj_misc), .inj_gstat(inj_gstat),
    .inj_uncond(inj_uncond), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mce_irq(mce_irq), .reset_req(reset_req)
  );

  function automatic logic [4:0] ba(int b, int f);
    return 5'(4 + 4 * b + f);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rdchk(string tag, logic [4:0] a, logic [63:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic inj(logic [7:0] b, logic [63:0] st, logic [63:0] ad,
                     logic [63:0] mi, logic [63:0] gs, logic unc,
                     output logic irq, output logic rq);
    @(negedge clk);
    inj_bank = b; inj_status = st; inj_addr = ad; inj_misc = mi;
    inj_gstat = gs; inj_uncond = unc; inj_valid = 1;
    @(posedge clk);
    #1 irq = mce_irq; rq = reset_req;
    @(negedge clk);
    inj_valid = 0; inj_uncond = 0;
  endtask

  task automatic t_reset;
    chk("R1 irq", 64'(mce_irq), 0);
    chk("R1 rst", 64'(reset_req), 0);
    rdchk("R1 cap", 5'd0, 64'h104);
    rdchk("R1 gstat", 5'd1, 0);
    rdchk("R1 gctl", 5'd2, 0);
    rdchk("R1 b1 status", ba(1, 1), 0);
    rdchk("R1 b0 ctl", ba(0, 0), 0);
  endtask

  task automatic t_regport;
    wr(ba(2, 3), 64'hABC);
    rdchk("R2 b2 misc", ba(2, 3), 64'hABC);
    wr(5'd3, 64'h77);
    rdchk("R2 addr3 zero", 5'd3, 0);
  endtask

  task automatic t_uc_log;
    logic i, r;
    wr(5'd2, ONES);
    wr(ba(0, 0), ONES);
    inj(0, VAL | UC | 64'h11, 64'h1000, 64'h22, 64'h5, 0, i, r);
    chk("R7 irq", 64'(i), 1);
    chk("R11 no rst", 64'(r), 0);
    @(posedge clk); #1 chk("R11 irq one cycle", 64'(mce_irq), 0);
    rdchk("R7 status", ba(0, 1), VAL | UC | 64'h11);
    rdchk("R7 addr", ba(0, 2), 64'h1000);
    rdchk("R7 misc", ba(0, 3), 64'h22);
    rdchk("R7 gstat", 5'd1, 64'h5);
    wr(5'd1, 0);
    inj(0, VAL | UC | 64'h33, 64'h2000, 64'h44, 64'h1, 0, i, r);
    chk("R7 irq2", 64'(i), 1);
    rdchk("R7 overflow", ba(0, 1), VAL | OVR | UC | 64'h33);
    rdchk("R7 gstat2", 5'd1, 64'h1);
  endtask

  task automatic t_uc_reset;
    logic i, r;
    wr(5'd1, 64'h4);
    inj(0, VAL | UC | AR | 64'h55, 64'h3000, 0, 0, 0, i, r);
    chk("R6 rst busy", 64'(r), 1);
    chk("R6 no irq", 64'(i), 0);
    @(posedge clk); #1 chk("R11 rst one cycle", 64'(reset_req), 0);
    rdchk("R6 addr kept", ba(0, 2), 64'h2000);
    rdchk("R6 gstat kept", 5'd1, 64'h4);
    wr(5'd1, 0);
    mce_en = 0;
    inj(0, VAL | UC | 64'h66, 64'h3100, 0, 0, 0, i, r);
    mce_en = 1;
    chk("R6 rst disabled", 64'(r), 1);
    rdchk("R6 status kept", ba(0, 1), VAL | OVR | UC | 64'h33);
  endtask

  task automatic t_ignore;
    logic i, r;
    wr(5'd1, 64'h4);
    inj(3, VAL | 64'h77, 64'h4000, 0, 0, 0, i, r);
    rdchk("R4 ignored", ba(3, 1), 0);
    inj(3, VAL | 64'h77, 64'h4000, 0, 0, 1, i, r);
    chk("R4 uncond no irq", 64'(i), 0);
    rdchk("R4 uncond logged", ba(3, 1), VAL | 64'h77);
    wr(5'd1, 0);
  endtask

  task automatic t_drop;
    logic i, r;
    inj(1, VAL | UC | 64'h88, 64'h5000, 0, 0, 0, i, r);
    chk("R5 bank ctl drop irq", 64'(i | r), 0);
    rdchk("R5 bank ctl drop", ba(1, 1), 0);
    wr(ba(1, 0), ONES);
    wr(5'd2, 0);
    inj(1, VAL | UC | 64'h88, 64'h5000, 0, 0, 0, i, r);
    chk("R5 gctl drop irq", 64'(i | r), 0);
    rdchk("R5 gctl drop", ba(1, 1), 0);
    wr(5'd0, 64'h004);
    inj(1, VAL | UC | 64'h88, 64'h5000, 0, 0, 0, i, r);
    chk("R5 no ctlp logs", 64'(i), 1);
    rdchk("R5 logged", ba(1, 1), VAL | UC | 64'h88);
    wr(5'd0, 64'h104);
    wr(5'd2, ONES);
  endtask

  task automatic t_corrected;
    logic i, r;
    inj(2, VAL | 64'h10, 64'h6000, 64'h61, 64'h7, 0, i, r);
    chk("R8 no pulse", 64'(i | r), 0);
    rdchk("R8 status", ba(2, 1), VAL | 64'h10);
    rdchk("R8 gstat kept", 5'd1, 0);
    inj(2, VAL | 64'h20, 64'h7000, 64'h71, 64'h7, 0, i, r);
    rdchk("R8 overflow", ba(2, 1), VAL | OVR | 64'h20);
    rdchk("R8 addr", ba(2, 2), 64'h7000);
    inj(1, VAL | 64'h30, 64'h8000, 64'h81, 0, 0, i, r);
    chk("R9 no pulse", 64'(i | r), 0);
    rdchk("R9 over only", ba(1, 1), VAL | OVR | UC | 64'h88);
    rdchk("R9 addr kept", ba(1, 2), 64'h5000);
  endtask

  task automatic t_reject;
    logic i, r;
    wr(5'd0, 64'h102);
    inj(2, VAL | 64'h40, 64'h9000, 0, 0, 0, i, r);
    rdchk("R3 bank bound", ba(2, 2), 64'h7000);
    wr(5'd0, 64'h104);
    inj(3, 64'h40, 64'h9000, 0, 0, 0, i, r);
    rdchk("R3 not valid", ba(3, 2), 64'h4000);
    wr(5'd0, 0);
    inj(0, VAL | UC | 64'h40, 64'h9000, 0, 0, 0, i, r);
    chk("R3 cap zero pulse", 64'(i | r), 0);
    wr(5'd0, 64'h104);
    rdchk("R3 cap zero", ba(0, 2), 64'h2000);
  endtask

  task automatic t_priority;
    @(negedge clk);
    reg_we = 1; reg_addr = ba(3, 0); reg_wdata = 64'h5A;
    inj_bank = 3; inj_status = VAL | 64'h50; inj_addr = 64'hA000;
    inj_misc = 0; inj_gstat = 0; inj_uncond = 1; inj_valid = 1;
    @(negedge clk);
    reg_we = 0; inj_valid = 0; inj_uncond = 0;
    rdchk("R10 write applied", ba(3, 0), 64'h5A);
    rdchk("R10 inject discarded", ba(3, 2), 64'h4000);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_regport();
    t_uc_log();
    t_uc_reset();
    t_ignore();
    t_drop();
    t_corrected();
    t_reject();
    t_priority();
    finish_run();
  end
endmodule